// File: doc/BRIEF.md
# Serial Converter Capture Host

This block is the host-side master for a three-wire successive-approximation converter. It drives an active-low chip select and a serial clock derived from the system clock, and reads back 16-bit frames. From each frame it keeps the N data bits and drops the zero padding before and after them. It returns the result as a parallel word with a one-cycle strobe, and it holds chip select high for a programmable quiet interval after every frame.

A request is a `start` pulse, sampled while the block is idle, and it ends with a one-cycle `done` pulse. The mode, divider and quiet settings are captured when the request is accepted. In continuous mode a request runs one full conversion and leaves the converter powered, so holding `start` high gives back-to-back sampling. In power-saving mode a request wakes the converter with a dummy conversion whose result is thrown away. It then runs one valid conversion. Last, it opens a third frame and raises chip select right after the second serial-clock fall, which sends the converter back to shutdown.

Top module: `adc_capture_host`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `adcCsN` and `adcSclk` are high and `resultValid` and `done` are low.
- R2: With divider setting D, every high and every low phase of `adcSclk` inside a frame lasts D+1 system clocks, and that includes the high phase between the fall of `adcCsN` and the first serial-clock fall.
- R3: A full frame contains exactly 16 falling edges of `adcSclk`, and `adcCsN` rises D+1 system clocks after the 16th rising edge.
- R4: At each serial-clock fall, the level present on `adcSdata` just before that fall is sampled. Counting falls from 1 after `adcCsN` falls, the samples at falls 5 to 4+N form the result, with the sample at fall 5 as the MSB. All other samples of the frame are ignored.
- R5: `resultValid` is high for exactly one cycle, the first cycle in which `adcCsN` is high after a valid frame. It is not raised for a dummy frame or a truncated frame.
- R6: Between two frames of one request, `adcCsN` stays high for exactly Q+1 system clocks, where Q is the quiet setting. Between the last frame of one request and the first frame of the next, it stays high for at least Q+1 clocks.
- R7: A power-saving request (`cfgLowPower`=1) produces three chip-select windows: a full dummy frame, a full valid frame and a truncated frame. `result` takes the data of the second frame only.
- R8: The truncated frame has exactly 2 serial-clock falls. `adcCsN` rises at the end of the low phase after the 2nd fall, in the same cycle that `adcSclk` returns high.
- R9: `done` is a one-cycle pulse, issued once per request, with `adcCsN` high. A `start` pulse received while a request is in progress has no effect.
- R10: The mode, divider and quiet inputs are captured when `start` is accepted. Changing them during a request does not alter that request's timing.
- R11: `adcSclk` is high in every cycle in which `adcCsN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| cfgLowPower | input | 1 | 1 = power-saving sequence, 0 = single continuous-mode conversion |
| cfgHalfDiv | input | DIV_W | Serial-clock half period minus one, in system clocks |
| cfgQuiet | input | QUIET_W | Chip-select quiet time minus one, in system clocks |
| done | output | 1 | One-cycle pulse at the end of a request |
| adcCsN | output | 1 | Converter chip select, active low |
| adcSclk | output | 1 | Converter serial clock, idles high |
| adcSdata | input | 1 | Converter serial data |
| result | output | DATA_BITS | Last valid conversion result |
| resultValid | output | 1 | One-cycle strobe for a new `result` |

## Verification
The bound checker watches the converter-facing pins on every cycle. It checks that the serial clock idles high with chip select high, that every chip-select window closes after either 16 falls or 2 falls, and that the result and done strobes are single pulses tied to a chip-select rise. The bench scenarios are needed for the rest. They show that the sampled bit positions are correct, that the dummy result and the padding bits never reach `result`, that the half-period and quiet lengths are exact, that the settings are captured at acceptance, and that a `start` pulse during a busy request is ignored. Each of these is swept over several divider values, quiet values, data words and pad levels.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;

  // serial frame geometry, in serial-clock falls
  localparam int FRAME_BITS = 16;
  localparam int LEAD_SKIP  = 4;   // samples dropped before the MSB
  localparam int SHUT_EDGE  = 2;   // falls seen before chip select is pulled up early

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_QUIET
  } ctrlState_t;

  typedef enum logic [1:0] {
    FR_DUMMY,
    FR_VALID,
    FR_SHUT
  } frameKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic shiftIn;
    logic loadResult;
  } capStrobe_t;

endpackage

// File: rtl/adc_cap_ctrl.sv
`timescale 1ns/1ps
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_BITS = 12,
  parameter int DIV_W     = 8,
  parameter int QUIET_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               cfgLowPower,
  input  logic [DIV_W-1:0]   cfgHalfDiv,
  input  logic [QUIET_W-1:0] cfgQuiet,
  output logic               csN,
  output logic               sclk,
  output logic               done,
  output capStrobe_t         strobe
);

  localparam int EDGE_W = $clog2(FRAME_BITS + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_BITS);
  localparam logic [EDGE_W-1:0] KEEP_LO   = EDGE_W'(LEAD_SKIP + 1);
  localparam logic [EDGE_W-1:0] KEEP_HI   = EDGE_W'(LEAD_SKIP + DATA_BITS);
  localparam logic [EDGE_W-1:0] CUT_EDGE  = EDGE_W'(SHUT_EDGE);

  ctrlState_t         state;
  frameKind_t         kind;
  logic               lowPowerQ;
  logic               lastFrame;
  logic [DIV_W-1:0]   divQ;
  logic [DIV_W-1:0]   halfCnt;
  logic [QUIET_W-1:0] quietQ;
  logic [QUIET_W-1:0] quietCnt;
  logic [EDGE_W-1:0]  edgeCnt;
  logic [EDGE_W-1:0]  nextEdge;

  logic halfEnd, fallNow, frameEnd, cutNow, quietEnd;

  always_comb begin
    halfEnd  = (halfCnt == divQ);
    nextEdge = edgeCnt + 1'b1;
    fallNow  = (state == ST_FRAME) && halfEnd && sclk && (edgeCnt != LAST_EDGE);
    frameEnd = (state == ST_FRAME) && halfEnd && sclk && (edgeCnt == LAST_EDGE);
    cutNow   = (state == ST_FRAME) && halfEnd && !sclk &&
               (kind == FR_SHUT) && (edgeCnt == CUT_EDGE);
    quietEnd = (state == ST_QUIET) && (quietCnt == quietQ);

    strobe.shiftIn    = fallNow && (nextEdge >= KEEP_LO) && (nextEdge <= KEEP_HI);
    strobe.loadResult = frameEnd && (kind == FR_VALID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= FR_VALID;
      lowPowerQ <= 1'b0;
      lastFrame <= 1'b0;
      divQ      <= '0;
      halfCnt   <= '0;
      quietQ    <= '0;
      quietCnt  <= '0;
      edgeCnt   <= '0;
      csN       <= 1'b1;
      sclk      <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lowPowerQ <= cfgLowPower;
            divQ      <= cfgHalfDiv;
            quietQ    <= cfgQuiet;
            kind      <= cfgLowPower ? FR_DUMMY : FR_VALID;
            state     <= ST_FRAME;
            csN       <= 1'b0;
            sclk      <= 1'b1;
            halfCnt   <= '0;
            edgeCnt   <= '0;
          end
        end

        ST_FRAME: begin
          if (!halfEnd) begin
            halfCnt <= halfCnt + 1'b1;
          end else begin
            halfCnt <= '0;
            if (sclk) begin
              if (frameEnd) begin
                csN      <= 1'b1;
                state    <= ST_QUIET;
                quietCnt <= '0;
                unique case (kind)
                  FR_DUMMY: begin
                    kind      <= FR_VALID;
                    lastFrame <= 1'b0;
                  end
                  FR_VALID: begin
                    kind      <= FR_SHUT;
                    lastFrame <= !lowPowerQ;
                  end
                  default: lastFrame <= 1'b1;
                endcase
              end else begin
                sclk    <= 1'b0;
                edgeCnt <= nextEdge;
              end
            end else begin
              sclk <= 1'b1;
              if (cutNow) begin
                csN       <= 1'b1;
                state     <= ST_QUIET;
                quietCnt  <= '0;
                lastFrame <= 1'b1;
              end
            end
          end
        end

        ST_QUIET: begin
          if (quietEnd) begin
            if (lastFrame) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state   <= ST_FRAME;
              csN     <= 1'b0;
              halfCnt <= '0;
              edgeCnt <= '0;
            end
          end else begin
            quietCnt <= quietCnt + 1'b1;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_cap_dp.sv
`timescale 1ns/1ps
module adc_cap_dp
  import adc_cap_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  capStrobe_t           strobe,
  input  logic                 sdata,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid
);

  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      if (strobe.shiftIn) begin
        shiftReg <= {shiftReg[DATA_BITS-2:0], sdata};
      end
      resultValid <= strobe.loadResult;
      if (strobe.loadResult) begin
        result <= shiftReg;
      end
    end
  end

endmodule

// File: rtl/adc_capture_host.sv
`timescale 1ns/1ps
module adc_capture_host
  import adc_cap_pkg::*;
#(
  parameter int DATA_BITS = 12,
  parameter int DIV_W     = 8,
  parameter int QUIET_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 cfgLowPower,
  input  logic [DIV_W-1:0]     cfgHalfDiv,
  input  logic [QUIET_W-1:0]   cfgQuiet,
  output logic                 done,
  output logic                 adcCsN,
  output logic                 adcSclk,
  input  logic                 adcSdata,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid
);

  capStrobe_t capStrobe;

  adc_cap_ctrl #(
    .DATA_BITS (DATA_BITS),
    .DIV_W     (DIV_W),
    .QUIET_W   (QUIET_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cfgLowPower (cfgLowPower),
    .cfgHalfDiv  (cfgHalfDiv),
    .cfgQuiet    (cfgQuiet),
    .csN         (adcCsN),
    .sclk        (adcSclk),
    .done        (done),
    .strobe      (capStrobe)
  );

  adc_cap_dp #(
    .DATA_BITS (DATA_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (capStrobe),
    .sdata       (adcSdata),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/adc_capture_host_chk.sv
`timescale 1ns/1ps
module adc_capture_host_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic resultValid,
  input logic done
);

  logic       sclkQ;
  logic [4:0] fallCnt;

  // falls of the serial clock inside the current chip-select window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b1;
      fallCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        fallCnt <= '0;
      end else if (sclkQ && !sclk && fallCnt != 5'd31) begin
        fallCnt <= fallCnt + 1'b1;
      end
    end
  end

  a_r11_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  a_r3_fall_cap: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (fallCnt <= 5'd16));

  // R3 and R8: a window closes after a full frame or after the shutdown cut
  a_r8_window_close: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (fallCnt == 5'd16 || fallCnt == 5'd2));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r5_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(csN));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

endmodule

bind adc_capture_host adc_capture_host_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csN         (adcCsN),
  .sclk        (adcSclk),
  .resultValid (resultValid),
  .done        (done)
);

// File: tb/adc_capture_host_bench.sv
`timescale 1ns/1ps
module adc_capture_host_bench;

  localparam int NB = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          cfgLowPower = 1'b0;
  logic [3:0]    cfgHalfDiv = '0;
  logic [3:0]    cfgQuiet = '0;
  logic          adcSdata;
  logic          done;
  logic          adcCsN;
  logic          adcSclk;
  logic [NB-1:0] result;
  logic          resultValid;

  adc_capture_host #(
    .DATA_BITS (NB),
    .DIV_W     (4),
    .QUIET_W   (4)
  ) u_adc_capture_host (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cfgLowPower (cfgLowPower),
    .cfgHalfDiv  (cfgHalfDiv),
    .cfgQuiet    (cfgQuiet),
    .done        (done),
    .adcCsN      (adcCsN),
    .adcSclk     (adcSclk),
    .adcSdata    (adcSdata),
    .result      (result),
    .resultValid (resultValid)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int            devFrames = 0;
  int            frameBase = 0;
  int            bitIdx = 0;
  int            curRel = 0;
  logic [NB-1:0] wordA = '0;
  logic [NB-1:0] wordB = '0;
  logic          padBit = 1'b0;

  function automatic logic devBit(input int j, input logic [NB-1:0] w, input logic pad);
    if (j >= 4 && j < 4 + NB) return w[NB + 3 - j];
    return pad;
  endfunction

  initial begin
    adcSdata = 1'b0;
    forever begin
      @(negedge adcCsN or negedge adcSclk);
      if (adcSclk) begin
        bitIdx = 0;
        curRel = devFrames - frameBase;
        devFrames++;
      end else begin
        bitIdx++;
      end
      #1 adcSdata = devBit(bitIdx, (curRel == 0) ? wordA : wordB, padBit);
    end
  end

  // ---------------- pin monitor ----------------
  int            expHalf = 1;
  int            winIdx = 0;
  int            fallIdx = 0;
  int            winFalls = 0;
  int            sclkRun = 0;
  int            csHighRun = 0;
  int            halfErrs = 0;
  int            idleErrs = 0;
  int            rvCount = 0;
  int            rvTimingErr = 0;
  int            doneCount = 0;
  int            winLog [0:63];
  int            quietLog [0:63];
  logic [NB-1:0] rvValue = '0;
  logic          prevCs = 1'b1;
  logic          prevSclk = 1'b1;

  always @(negedge clk) begin
    if (!adcCsN && prevSclk && !adcSclk) winFalls++;
    if (!adcCsN && prevCs) begin
      sclkRun = 1;
    end else if (!prevCs && (adcSclk != prevSclk)) begin
      if (sclkRun != expHalf) halfErrs++;
      sclkRun = 1;
    end else if (!prevCs && adcCsN) begin
      if (sclkRun != expHalf) halfErrs++;
    end else begin
      sclkRun++;
    end
    if (adcCsN) begin
      csHighRun++;
    end else if (prevCs) begin
      quietLog[fallIdx % 64] = csHighRun;
      fallIdx++;
      csHighRun = 0;
    end
    if (!prevCs && adcCsN) begin
      winLog[winIdx % 64] = winFalls;
      winIdx++;
      winFalls = 0;
    end
    if (adcCsN && !adcSclk) idleErrs++;
    if (resultValid) begin
      rvCount++;
      rvValue = result;
      if (!(adcCsN && !prevCs)) rvTimingErr++;
    end
    if (done) doneCount++;
    prevCs   = adcCsN;
    prevSclk = adcSclk;
  end

  // ---------------- one request ----------------
  int lastQ = 0;

  task automatic runReq(input logic lp, input int d, input int q,
                        input logic [NB-1:0] wA, input logic [NB-1:0] wB,
                        input logic pad, input logic poke);
    int w0, f0, rv0, dn0, he0, ie0, rt0, cyc, expWin;
    logic [NB-1:0] expWord;
    wordA   = wA;
    wordB   = wB;
    padBit  = pad;
    expHalf = d + 1;
    expWin  = lp ? 3 : 1;
    expWord = lp ? wB : wA;
    @(negedge clk);
    cfgLowPower = lp;
    cfgHalfDiv  = 4'(d);
    cfgQuiet    = 4'(q);
    start       = 1'b1;
    frameBase = devFrames;
    w0 = winIdx; f0 = fallIdx; rv0 = rvCount; dn0 = doneCount;
    he0 = halfErrs; ie0 = idleErrs; rt0 = rvTimingErr;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble settings once the request is accepted
    cfgLowPower = ~lp;
    cfgHalfDiv  = ~4'(d);
    cfgQuiet    = ~4'(q);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke) start = (cyc == 30);
    end
    start = 1'b0;
    repeat (q + 6) @(negedge clk);

    check("R9 request completes", int'(cyc < 20000), 1);
    check("R9 one done pulse per request", doneCount - dn0, 1);
    check("R3 R7 chip-select windows", winIdx - w0, expWin);
    check("R9 start during busy ignored", fallIdx - f0, expWin);
    check("R3 falls in first window", winLog[w0 % 64], 16);
    if (lp) begin
      check("R7 falls in valid window", winLog[(w0 + 1) % 64], 16);
      check("R8 falls in truncated window", winLog[(w0 + 2) % 64], 2);
      check("R6 R10 quiet before valid frame", quietLog[(f0 + 1) % 64], q + 1);
      check("R6 R10 quiet before shutdown frame", quietLog[(f0 + 2) % 64], q + 1);
    end
    check("R6 quiet between requests", int'(quietLog[f0 % 64] >= lastQ + 1), 1);
    check("R2 R10 half period mismatches", halfErrs - he0, 0);
    check("R11 clock low with chip select high", idleErrs - ie0, 0);
    check("R5 valid strobe count", rvCount - rv0, 1);
    check("R5 valid strobe timing", rvTimingErr - rt0, 0);
    check("R4 R7 result word", int'(rvValue), int'(expWord));
    lastQ = q;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #800000;
    errors++;
    $display("FAIL R9 watchdog: actual no finish expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 chip select high in reset", int'(adcCsN), 1);
    check("R1 serial clock high in reset", int'(adcSclk), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 chip select high after reset", int'(adcCsN), 1);
    check("R1 serial clock high after reset", int'(adcSclk), 1);
    check("R1 valid low after reset", int'(resultValid), 0);
    check("R1 done low after reset", int'(done), 0);

    // corners: extreme words, padding driven high, dummy differs from valid
    runReq(1'b0, 0, 0, 12'hFFF, 12'h000, 1'b1, 1'b1);
    runReq(1'b0, 1, 2, 12'h001, 12'hFFF, 1'b1, 1'b0);
    runReq(1'b1, 2, 3, 12'hFFF, 12'h000, 1'b1, 1'b1);
    runReq(1'b1, 0, 0, 12'h123, 12'h800, 1'b0, 1'b0);
    runReq(1'b1, 1, 1, 12'h000, 12'h001, 1'b1, 1'b0);

    for (int lp = 0; lp < 2; lp++) begin
      for (int di = 0; di < 3; di++) begin
        for (int qi = 0; qi < 3; qi++) begin
          int d;
          int q;
          logic [NB-1:0] a;
          d = (di == 2) ? 3 : di;
          q = (qi == 2) ? 4 : qi;
          a = NB'((lp * 9 + di * 3 + qi) * 713 + 53);
          runReq(1'(lp), d, q, a, ~a, 1'(qi), di == 1);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule